// File: doc/BRIEF.md
# Registered Single-Outstanding Data Bus Master

This block sits between a simple in-order core and a memory slave built like a block RAM, which registers its output. The core hands it one load or store at a time, as a byte address, a transfer size (byte, halfword or word), a sign flag and store data. The block turns each request into exactly one bus access with a one-cycle address strobe. It then waits for the slave's registered ready and returns a done pulse to the core, together with the extracted and extended load value.

The access timing does not depend on the address or the data. The request is accepted in cycle 0, the strobe is driven in cycle 1, the slave answers in cycle 2, and done is high in cycle 3. Byte and halfword stores enable only the lanes they address, so the block never reads and rewrites a word. Loads always fetch the whole word, and the lane is picked inside the block. The strobe never stays high across two accesses. A new request can be accepted in the done cycle at the earliest, so at least one bus cycle separates one access's ready from the next strobe.

The control is a four-state machine:
- IDLE: no access.
- ISSUE: the strobe cycle.
- WAIT: waiting for ready.
- DONE: the one-cycle completion.

Its transitions are:
- IDLE to ISSUE on a request.
- ISSUE to WAIT always.
- WAIT stays in WAIT until ready, then goes to DONE.
- DONE goes to ISSUE on a new request, otherwise back to IDLE.

Top module: `dbus_master`

## Requirements
- R1: At most one access is outstanding. `busy` is high from the cycle after acceptance until the ready cycle inclusive. A request presented while `busy` is high is ignored: it causes no strobe and no memory write.
- R2: A request is accepted only in IDLE or DONE. Its `bus_as` strobe is high for exactly the one cycle after acceptance, and is never high in two consecutive cycles.
- R3: `bus_addr` (the full byte address), `bus_be`, `bus_wdata`, `bus_we` and `bus_re` stay stable from the strobe cycle through the ready cycle.
- R4: During an access, exactly one of `bus_we` (store) or `bus_re` (load) is high. Both are low when no access is in flight, so the slave write enable is `bus_as & bus_we` and the read enable is `bus_as & bus_re`.
- R5: `bus_ready` and `bus_rdata` are sampled only in the cycle after the strobe or later (WAIT). `done` is high for exactly the one cycle after ready is seen, and `rdata` is valid in that cycle.
- R6: The size encoding is 2'b00 byte, 2'b01 halfword, 2'b10 and 2'b11 word. Store byte enables are as follows:
  - word: 4'b1111
  - halfword: 4'b0011 when address bit 1 is 0, 4'b1100 when it is 1
  - byte: the one-hot value 1 << addr[1:0]
  - loads: always 4'b1111
- R7: Store data is placed on every lane. A byte store drives the byte on all four lanes, a halfword store drives the halfword in both halves, and a word store drives the word unchanged.
- R8: A load returns the selected lane, shifted down by 8 × addr[1:0] bits. Byte and halfword results are sign-extended when `req_signed` is 1 and zero-extended when it is 0. Word loads return the full word.
- R9: The latency is fixed, with `done` three cycles after the request cycle for any data or address. A request presented in the DONE cycle gets its strobe in the next cycle, which leaves exactly one cycle without the strobe between the previous ready and the new strobe.
- R10: A synchronous active-high `rst` returns the block to IDLE on the next clock edge. After that edge `bus_as`, `bus_we`, `bus_re`, `busy` and `done` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 half, 10/11 word |
| req_signed | input | 1 | Sign-extend a sub-word load |
| req_addr | input | ADDR_W | Byte address (aligned for its size) |
| req_wdata | input | DATA_W | Store data, right-justified |
| busy | output | 1 | Access in flight; requests ignored |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Aligned, extended load result |
| bus_addr | output | ADDR_W | Bus byte address |
| bus_wdata | output | DATA_W | Lane-replicated store data |
| bus_we | output | 1 | Write qualifier of the strobe |
| bus_re | output | 1 | Read qualifier of the strobe |
| bus_as | output | 1 | One-cycle address strobe |
| bus_be | output | DATA_W/8 | Byte lane enables |
| bus_rdata | input | DATA_W | Slave read data |
| bus_ready | input | 1 | Slave completion, one cycle after the strobe |

## Verification
If the request is held in cycle 0, the strobe with its byte enables, address and data is due in cycle 1. The bench model of the slave raises ready in cycle 2, and `done` and `rdata` are due in cycle 3. The bench drives inputs on falling edges and samples each of these results on the falling edge inside the exact cycle it is due. It also checks the cycles in between, so an early or late output is caught as well as a wrong one. For the back-to-back case, the bench drives the next request in the done cycle and expects the new strobe in cycle 4.

// File: rtl/dbus_pkg.sv
package dbus_pkg;

    localparam logic [1:0] SZ_BYTE = 2'b00;
    localparam logic [1:0] SZ_HALF = 2'b01;
    localparam logic [1:0] SZ_WORD = 2'b10;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } bus_state_e;

endpackage

// File: rtl/dbus_lane_gen.sv
module dbus_lane_gen
    import dbus_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int NB    = DATA_W / 8,
    localparam int OFF_W = $clog2(NB)
) (
    input  logic              is_write,
    input  logic [1:0]        size,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] wdata_in,
    output logic [NB-1:0]     be,
    output logic [DATA_W-1:0] wdata_out
);

    always_comb begin
        if (!is_write) begin
            be = '1;
        end else begin
            case (size)
                SZ_BYTE: be = NB'(1) << off;
                SZ_HALF: be = NB'(3) << {off[OFF_W-1:1], 1'b0};
                default: be = '1;
            endcase
        end
    end

    for (genvar i = 0; i < NB; i++) begin : g_lane
        always_comb begin
            case (size)
                SZ_BYTE: wdata_out[i*8 +: 8] = wdata_in[7:0];
                SZ_HALF: wdata_out[i*8 +: 8] = wdata_in[(i % 2)*8 +: 8];
                default: wdata_out[i*8 +: 8] = wdata_in[i*8 +: 8];
            endcase
        end
    end

endmodule

// File: rtl/dbus_load_align.sv
module dbus_load_align
    import dbus_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int NB    = DATA_W / 8,
    localparam int OFF_W = $clog2(NB)
) (
    input  logic [DATA_W-1:0] raw,
    input  logic [1:0]        size,
    input  logic              sgn,
    input  logic [OFF_W-1:0]  off,
    output logic [DATA_W-1:0] result
);

    logic [DATA_W-1:0] shifted;

    always_comb begin
        shifted = raw >> {off, 3'b000};
        case (size)
            SZ_BYTE: result = {{(DATA_W-8){sgn & shifted[7]}}, shifted[7:0]};
            SZ_HALF: result = {{(DATA_W-16){sgn & shifted[15]}}, shifted[15:0]};
            default: result = raw;
        endcase
    end

endmodule

// File: rtl/dbus_master.sv
module dbus_master
    import dbus_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int NB    = DATA_W / 8,
    localparam int OFF_W = $clog2(NB)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic              req_signed,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_we,
    output logic              bus_re,
    output logic              bus_as,
    output logic [NB-1:0]     bus_be,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ready
);

    bus_state_e state_q, state_d;

    logic              accept;
    logic              write_q, sgn_q;
    logic [1:0]        size_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rdata_q, wdata_lanes, load_val;
    logic [NB-1:0]     be_q, be_d;

    // acceptance only when no access is in flight
    assign accept = req_valid && (state_q == ST_IDLE || state_q == ST_DONE);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_ISSUE;
            ST_ISSUE: state_d = ST_WAIT;
            ST_WAIT:  if (bus_ready) state_d = ST_DONE;
            ST_DONE:  state_d = accept ? ST_ISSUE : ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // outputs decoded from state
    always_comb begin
        bus_as = 1'b0;
        busy   = 1'b0;
        done   = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_ISSUE: begin bus_as = 1'b1; busy = 1'b1; end
            ST_WAIT:  busy = 1'b1;
            ST_DONE:  done = 1'b1;
        endcase
        bus_we = busy &  write_q;
        bus_re = busy & ~write_q;
    end

    dbus_lane_gen #(.DATA_W(DATA_W)) u_lanes (
        .is_write  (req_write),
        .size      (req_size),
        .off       (req_addr[OFF_W-1:0]),
        .wdata_in  (req_wdata),
        .be        (be_d),
        .wdata_out (wdata_lanes)
    );

    dbus_load_align #(.DATA_W(DATA_W)) u_align (
        .raw    (bus_rdata),
        .size   (size_q),
        .sgn    (sgn_q),
        .off    (addr_q[OFF_W-1:0]),
        .result (load_val)
    );

    // request capture and load result
    always_ff @(posedge clk) begin
        if (rst) begin
            write_q <= 1'b0;
            sgn_q   <= 1'b0;
            size_q  <= SZ_WORD;
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                write_q <= req_write;
                sgn_q   <= req_signed;
                size_q  <= req_size;
                addr_q  <= req_addr;
                wdata_q <= wdata_lanes;
                be_q    <= be_d;
            end
            if (state_q == ST_WAIT && bus_ready && !write_q)
                rdata_q <= load_val;
        end
    end

    assign bus_addr  = addr_q;
    assign bus_wdata = wdata_q;
    assign bus_be    = be_q;
    assign rdata     = rdata_q;

endmodule

// File: rtl/dbus_master_chk.sv
module dbus_master_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int NB    = DATA_W / 8
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_we,
    input logic              bus_re,
    input logic              bus_as,
    input logic [NB-1:0]     bus_be,
    input logic              bus_ready
);

    assert_strobe_single_R2: assert property (@(posedge clk) disable iff (rst)
        bus_as |=> !bus_as);

    assert_strobe_busy_R1: assert property (@(posedge clk) disable iff (rst)
        bus_as |=> busy);

    assert_no_done_while_busy_R1: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(bus_addr) && $stable(bus_be) &&
                                   $stable(bus_wdata) && $stable(bus_we) && $stable(bus_re)));

    assert_one_qualifier_R4: assert property (@(posedge clk) disable iff (rst)
        busy |-> $countones({bus_we, bus_re}) == 1);

    assert_idle_qualifiers_R4: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !bus_we && !bus_re && !bus_as);

    assert_done_after_ready_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && !bus_as && bus_ready) |=> done);

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_load_be_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_as && bus_re) |-> bus_be == '1);

    assert_reset_idle_R10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !bus_as && !busy && !done);

endmodule

bind dbus_master dbus_master_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .done      (done),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_as    (bus_as),
    .bus_be    (bus_be),
    .bus_ready (bus_ready)
);

// File: tb/sim_dbus_master.sv
`timescale 1ns/1ps
module sim_dbus_master;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0, req_signed = 1'b0;
    logic [1:0]  req_size = 2'b10;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        busy, done, bus_we, bus_re, bus_as;
    logic [31:0] rdata, bus_addr, bus_wdata;
    logic [3:0]  bus_be;
    logic [31:0] s_rdata = '0;
    logic        s_ready = 1'b0;

    int n_chk = 0, n_fail = 0, n_strobe = 0;
    logic [31:0] mem [16];
    logic [31:0] shadow [16];

    always #2.5 clk = ~clk;

    dbus_master u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_signed(req_signed), .req_addr(req_addr),
        .req_wdata(req_wdata), .busy(busy), .done(done), .rdata(rdata),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
        .bus_re(bus_re), .bus_as(bus_as), .bus_be(bus_be),
        .bus_rdata(s_rdata), .bus_ready(s_ready)
    );

    // registered block-RAM-style slave
    always @(posedge clk) begin
        s_ready <= bus_as & ~rst;
        if (bus_as) n_strobe <= n_strobe + 1;
        if (bus_as && bus_re) s_rdata <= mem[bus_addr[5:2]];
        if (bus_as && bus_we)
            for (int i = 0; i < 4; i++)
                if (bus_be[i]) mem[bus_addr[5:2]][i*8 +: 8] <= bus_wdata[i*8 +: 8];
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_be(input logic w, input logic [1:0] sz, input logic [1:0] off);
        if (!w) return 4'b1111;
        case (sz)
            2'b00:   return 4'b0001 << off;
            2'b01:   return off[1] ? 4'b1100 : 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [31:0] exp_wd(input logic [1:0] sz, input logic [31:0] d);
        case (sz)
            2'b00:   return {4{d[7:0]}};
            2'b01:   return {2{d[15:0]}};
            default: return d;
        endcase
    endfunction

    function automatic logic [31:0] exp_ld(input logic [31:0] w, input logic [1:0] sz,
                                           input logic sg, input logic [1:0] off);
        logic [31:0] s;
        s = w >> (8 * off);
        case (sz)
            2'b00:   return sg ? {{24{s[7]}}, s[7:0]} : {24'h0, s[7:0]};
            2'b01:   return sg ? {{16{s[15]}}, s[15:0]} : {16'h0, s[15:0]};
            default: return w;
        endcase
    endfunction

    // one access; intrude presents a conflicting store while busy
    task automatic access(input logic w, input logic [1:0] sz, input logic sg,
                          input logic [31:0] a, input logic [31:0] d, input bit intrude);
        logic [3:0] be;
        int s0;
        be = exp_be(w, sz, a[1:0]);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_size = sz; req_signed = sg;
        req_addr = a; req_wdata = d;
        s0 = n_strobe;
        @(negedge clk);                       // cycle 1: strobe
        req_valid = 1'b0;
        chk("R2 strobe in cycle 1", {31'h0, bus_as}, 32'h1);
        chk("R1 busy in strobe cycle", {31'h0, busy}, 32'h1);
        chk("R6 byte enables", {28'h0, bus_be}, {28'h0, be});
        chk("R3 address", bus_addr, a);
        chk("R4 qualifiers", {30'h0, bus_we, bus_re}, {30'h0, w, ~w});
        if (w) chk("R7 store lanes", bus_wdata, exp_wd(sz, d));
        if (intrude) begin
            req_valid = 1'b1; req_write = 1'b1; req_size = 2'b10;
            req_addr = 32'h14; req_wdata = 32'hDEAD_BEEF;
        end
        @(negedge clk);                       // cycle 2: ready
        chk("R2 strobe dropped", {31'h0, bus_as}, 32'h0);
        chk("R3 address held", bus_addr, a);
        chk("R5 no early done", {31'h0, done}, 32'h0);
        @(negedge clk);                       // cycle 3: done
        req_valid = 1'b0;
        chk("R9 done in cycle 3", {31'h0, done}, 32'h1);
        chk("R1 busy released", {31'h0, busy}, 32'h0);
        chk("R1 single strobe", n_strobe - s0, 1);
        if (!w) chk("R8 load result", rdata, exp_ld(shadow[a[5:2]], sz, sg, a[1:0]));
        else
            for (int i = 0; i < 4; i++)
                if (be[i]) shadow[a[5:2]][i*8 +: 8] = exp_wd(sz, d)[i*8 +: 8];
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin mem[i] = '0; shadow[i] = '0; end
        repeat (3) @(negedge clk);
        chk("R10 reset strobe", {31'h0, bus_as}, 32'h0);
        chk("R10 reset busy/done", {30'h0, busy, done}, 32'h0);
        chk("R10 reset qualifiers", {30'h0, bus_we, bus_re}, 32'h0);
        rst = 1'b0;

        // word stores with sign-bit-rich patterns
        for (int i = 0; i < 16; i++)
            access(1'b1, (i == 15) ? 2'b11 : 2'b10, 1'b0, 32'(i * 4),
                   32'h8F17_C35A ^ (32'h0101_0101 * i), 1'b0);
        // byte stores at every lane, halfword stores at both halves
        for (int o = 0; o < 4; o++)
            access(1'b1, 2'b00, 1'b0, 32'(8 + o), 32'h0000_7F80 + 32'(o * 37), 1'b0);
        for (int o = 0; o < 2; o++)
            access(1'b1, 2'b01, 1'b0, 32'(12 + 2 * o), 32'h1234_8001 + 32'(o * 32'h7000), 1'b0);

        // load sweep over every word, offset, size and sign
        for (int wd = 0; wd < 16; wd++)
            for (int o = 0; o < 4; o++)
                for (int sg = 0; sg < 2; sg++) begin
                    access(1'b0, 2'b00, sg[0], 32'(wd * 4 + o), '0, 1'b0);
                    if (o % 2 == 0) access(1'b0, 2'b01, sg[0], 32'(wd * 4 + o), '0, 1'b0);
                    if (o == 0)     access(1'b0, 2'b10, sg[0], 32'(wd * 4), '0, 1'b0);
                end

        // R1: request while busy is ignored; word 5 must be unchanged
        access(1'b0, 2'b10, 1'b0, 32'h20, '0, 1'b1);
        access(1'b0, 2'b10, 1'b0, 32'h14, '0, 1'b0);

        // R9: request in the done cycle is issued in the next cycle
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_size = 2'b10; req_addr = 32'h18;
        @(negedge clk); req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R9 done before chain", {31'h0, done}, 32'h1);
        chk("R9 no strobe in done cycle", {31'h0, bus_as}, 32'h0);
        req_valid = 1'b1; req_addr = 32'h1C;
        @(negedge clk); req_valid = 1'b0;
        chk("R9 chained strobe", {31'h0, bus_as}, 32'h1);
        chk("R9 chained address", bus_addr, 32'h1C);
        @(negedge clk);
        @(negedge clk);
        chk("R9 chained load", rdata, shadow[7]);

        // R10: reset in the middle of an access
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h4;
        @(negedge clk); req_valid = 1'b0; rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R10 mid-access reset idle", {29'h0, busy, done, bus_as}, 32'h0);
        chk("R10 mid-access qualifiers", {30'h0, bus_we, bus_re}, 32'h0);
        access(1'b0, 2'b00, 1'b1, 32'h9, '0, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule